// File: doc/BRIEF.md
# BCD Calendar Counter Chain

This block keeps the time of day and the calendar as a chain of synchronous BCD counters. A 100 Hz enable pulse from an external prescaler advances the fastest stage (hundredths of a second). Each stage passes a carry to the next stage when it wraps. The chain covers seconds, minutes, hours, day of week, day of month, month and a two-digit year. A separate three-digit BCD day-of-year count runs beside the calendar. Hours count either on a 24-hour dial or on a 12-hour dial with an AM/PM flag.

Leap years come from a two-bit count of the years since the last leap year, which the host sets. This count advances each time the year advances. When it reads zero, February has 29 days and the year has 366 days. The host loads any counter byte, and a control byte, through a single-cycle write port. It reads all of them back through a combinational read port. A run bit starts and stops the chain and also gates the prescaler. Registered rollover pulses mark the advance of the 10 ms, 100 ms, 1 s, 10 s and 1 min stages for periodic-interrupt logic.

Top module: `cal_chain`

## Requirements
- R1: Address 0 (hundredths, 00–99), address 1 (seconds, 00–59) and address 2 (minutes, 00–59) wrap to 00. The hundredths byte advances by one for each `tick` taken while running.
- R2: A stage advances only on a tick in which every faster stage wraps.
- R3: With control bit 1 clear, the hours byte (address 3) counts 00–23. It wraps from 23 to 00 and produces a day carry.
- R4: With control bit 1 set, hours bits 4:0 count 01–12 and hours bit 7 is PM. Going from 11 to 12 toggles bit 7. Going from 12 to 01 keeps bit 7. A day carry happens only when the hour goes from PM 11 to AM 12.
- R5: The day of month (address 4) wraps to 01 and advances the month (address 5) after day 31 in months 01, 03, 05, 07, 08, 10 and 12, and after day 30 in months 04, 06, 09 and 11. In month 02 it wraps after day 29 when the leap count is 0, and after day 28 otherwise.
- R6: A wrap of the month from 12 to 01 advances the year (address 6, 00–99, wraps to 00). It also advances the leap count (control bits 5:4, wrapping 3 to 0) and resets the day of year to 001.
- R7: The day of year is a 12-bit BCD value. Address 7 holds the low two digits and address 8 bits 3:0 hold the hundreds digit. It advances on each day carry and wraps to 001 after 366 when the leap count is 0, and after 365 otherwise.
- R8: The day of week (address 9) counts 1–7 and wraps to 1 on each day carry.
- R9: Control bit 0 is the run bit, and `presc_en` follows it. While the run bit is 0, ticks change no counter and produce no rollover pulse.
- R10: A write to address 0–10 loads that byte. The write takes priority over an increment of the same byte in the same cycle, while carries into other stages still come from the values before the write. Address 10 is the control byte: bit 0 run, bit 1 12-hour mode, bits 5:4 leap count.
- R11: `roll` bits 0–4 pulse for one cycle, in the cycle after the tick, when the 10 ms, 100 ms, 1 s, 10 s and 1 min stages advance respectively.
- R12: After reset the counters read hundredths, seconds, minutes, hours, year and the day-of-year hundreds digit as 00. Day of month, month, day-of-year low byte and day of week read 01. The control byte reads 00, and `presc_en` and `roll` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 100 Hz advance enable from the prescaler |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Host write byte address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | ADDR_W | Host read byte address |
| rd_data | output | 8 | Read data (combinational), 00 for unmapped addresses |
| presc_en | output | 1 | Prescaler enable; low holds the prescaler cleared |
| roll | output | 5 | Stage-advance pulses: 10 ms, 100 ms, 1 s, 10 s, 1 min |

## Verification
A table of preloaded calendar states is each advanced by one tick. The rows distinguish single-digit carries from whole-byte wraps, and the hour dial modes from each other. They also separate 30-day, 31-day and both February month ends, and ordinary year ends from leap and non-leap year ends. Rows where the day-of-year limit disagrees with the month end show that the day-of-year wrap comes from the leap count and not only from December. Directed cases then check that a same-cycle write overrides the written byte while still carrying from the old value. A stopped chain ignores ticks.

// File: rtl/cal_pkg.sv
package cal_pkg;

   localparam int NREG   = 11;
   localparam int A_FRAC = 0;
   localparam int A_SEC  = 1;
   localparam int A_MIN  = 2;
   localparam int A_HOUR = 3;
   localparam int A_DOM  = 4;
   localparam int A_MON  = 5;
   localparam int A_YEAR = 6;
   localparam int A_DOYL = 7;
   localparam int A_DOYH = 8;
   localparam int A_DOW  = 9;
   localparam int A_CTRL = 10;
   localparam int NROLL  = 5;

   function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
      if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
      return {v[7:4], v[3:0] + 4'h1};
   endfunction

   function automatic logic [11:0] bcd_inc12(input logic [11:0] v);
      logic [11:0] r;
      r = v;
      if (v[3:0] != 4'h9) r[3:0] = v[3:0] + 4'h1;
      else begin
         r[3:0] = 4'h0;
         if (v[7:4] != 4'h9) r[7:4] = v[7:4] + 4'h1;
         else begin
            r[7:4]  = 4'h0;
            r[11:8] = v[11:8] + 4'h1;
         end
      end
      return r;
   endfunction

   function automatic logic [7:0] month_days(input logic [7:0] mon, input logic leap_now);
      case (mon)
         8'h02:                      return leap_now ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/cal_bcd_byte.sv
module cal_bcd_byte
   import cal_pkg::*;
#(
   parameter logic [7:0] LOW_VAL = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step,
   input  logic       wr,
   input  logic [7:0] wr_data,
   input  logic [7:0] top_val,
   output logic [7:0] cnt,
   output logic       carry
);

   if (LOW_VAL[3:0] > 4'h9 || LOW_VAL[7:4] > 4'h9) begin : g_bad_low
      $error("cal_bcd_byte: LOW_VAL is not BCD");
   end

   logic [7:0] nxt;

   assign carry = step && (cnt == top_val);

   always_comb begin
      nxt = cnt;
      if (step) nxt = carry ? LOW_VAL : bcd_inc8(cnt);
      if (wr)   nxt = wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= LOW_VAL;
      else        cnt <= nxt;
   end

   assert_step_moves_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !wr && cnt != top_val) |=> (cnt != $past(cnt)));
   assert_wrap_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (carry && !wr) |=> (cnt == LOW_VAL));
   assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (cnt == $past(wr_data)));

endmodule

// File: rtl/cal_hour_byte.sv
module cal_hour_byte
   import cal_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step,
   input  logic       mode12,
   input  logic       wr,
   input  logic [7:0] wr_data,
   output logic [7:0] cnt,
   output logic       day_carry
);

   logic [7:0] dial;
   logic [7:0] dial_inc;
   logic [7:0] nxt;

   assign dial      = {3'b000, cnt[4:0]};
   assign dial_inc  = bcd_inc8(dial);
   assign day_carry = step && (mode12 ? (cnt[7] && cnt[4:0] == 5'h11) : (cnt == 8'h23));

   always_comb begin
      nxt = cnt;
      if (step) begin
         if (mode12) begin
            if (dial == 8'h12)      nxt = {cnt[7], 7'h01};
            else if (dial == 8'h11) nxt = {~cnt[7], 7'h12};
            else                    nxt = {cnt[7], dial_inc[6:0]};
         end else begin
            nxt = (cnt == 8'h23) ? 8'h00 : bcd_inc8(cnt);
         end
      end
      if (wr) nxt = wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= 8'h00;
      else        cnt <= nxt;
   end

   assert_pm_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !wr && mode12 && cnt[4:0] == 5'h11) |=> (cnt[7] != $past(cnt[7])));
   assert_day_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (day_carry && !wr && !mode12) |=> (cnt == 8'h00));

endmodule

// File: rtl/cal_doy_count.sv
module cal_doy_count
   import cal_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        step,
   input  logic        year_end,
   input  logic        leap_now,
   input  logic        wr_lo,
   input  logic        wr_hi,
   input  logic [7:0]  wr_data,
   output logic [11:0] doy
);

   logic        at_limit;
   logic [11:0] nxt;

   assign at_limit = (doy == (leap_now ? 12'h366 : 12'h365));

   always_comb begin
      nxt = doy;
      if (step) nxt = (at_limit || year_end) ? 12'h001 : bcd_inc12(doy);
      if (wr_lo) nxt[7:0]  = wr_data;
      if (wr_hi) nxt[11:8] = wr_data[3:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) doy <= 12'h001;
      else        doy <= nxt;
   end

   assert_doy_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (step && (at_limit || year_end) && !wr_lo && !wr_hi) |=> (doy == 12'h001));

endmodule

// File: rtl/cal_chain.sv
module cal_chain
   import cal_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter bit REG_ROLL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic              presc_en,
   output logic [NROLL-1:0]  roll
);

   if (ADDR_W < 4) begin : g_bad_addr
      $error("cal_chain: ADDR_W too small for the byte map");
   end

   logic [NREG-1:0] wsel;
   for (genvar g = 0; g < NREG; g++) begin : g_wsel
      assign wsel[g] = wr_en && (wr_addr == ADDR_W'(g));
   end

   logic       run, mode12;
   logic [1:0] leap;
   logic       step;
   logic [7:0] frac, sec, mins, hour, dom, mon, year, dow;
   logic [11:0] doy;
   logic       c_frac, c_sec, c_min, c_day, c_dom, c_mon, c_year, c_dow;
   logic [NROLL-1:0] roll_now;

   assign step     = tick && run;
   assign presc_en = run;

   cal_bcd_byte #(.LOW_VAL(8'h00)) u_frac (.clk(clk), .rst_n(rst_n), .step(step),
      .wr(wsel[A_FRAC]), .wr_data(wr_data), .top_val(8'h99), .cnt(frac), .carry(c_frac));
   cal_bcd_byte #(.LOW_VAL(8'h00)) u_sec (.clk(clk), .rst_n(rst_n), .step(c_frac),
      .wr(wsel[A_SEC]), .wr_data(wr_data), .top_val(8'h59), .cnt(sec), .carry(c_sec));
   cal_bcd_byte #(.LOW_VAL(8'h00)) u_min (.clk(clk), .rst_n(rst_n), .step(c_sec),
      .wr(wsel[A_MIN]), .wr_data(wr_data), .top_val(8'h59), .cnt(mins), .carry(c_min));

   cal_hour_byte u_hour (.clk(clk), .rst_n(rst_n), .step(c_min), .mode12(mode12),
      .wr(wsel[A_HOUR]), .wr_data(wr_data), .cnt(hour), .day_carry(c_day));

   cal_bcd_byte #(.LOW_VAL(8'h01)) u_dom (.clk(clk), .rst_n(rst_n), .step(c_day),
      .wr(wsel[A_DOM]), .wr_data(wr_data), .top_val(month_days(mon, leap == 2'd0)),
      .cnt(dom), .carry(c_dom));
   cal_bcd_byte #(.LOW_VAL(8'h01)) u_mon (.clk(clk), .rst_n(rst_n), .step(c_dom),
      .wr(wsel[A_MON]), .wr_data(wr_data), .top_val(8'h12), .cnt(mon), .carry(c_mon));
   cal_bcd_byte #(.LOW_VAL(8'h00)) u_year (.clk(clk), .rst_n(rst_n), .step(c_mon),
      .wr(wsel[A_YEAR]), .wr_data(wr_data), .top_val(8'h99), .cnt(year), .carry(c_year));
   cal_bcd_byte #(.LOW_VAL(8'h01)) u_dow (.clk(clk), .rst_n(rst_n), .step(c_day),
      .wr(wsel[A_DOW]), .wr_data(wr_data), .top_val(8'h07), .cnt(dow), .carry(c_dow));

   cal_doy_count u_doy (.clk(clk), .rst_n(rst_n), .step(c_day), .year_end(c_mon),
      .leap_now(leap == 2'd0), .wr_lo(wsel[A_DOYL]), .wr_hi(wsel[A_DOYH]),
      .wr_data(wr_data), .doy(doy));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run    <= 1'b0;
         mode12 <= 1'b0;
         leap   <= 2'd0;
      end else if (wsel[A_CTRL]) begin
         run    <= wr_data[0];
         mode12 <= wr_data[1];
         leap   <= wr_data[5:4];
      end else if (c_mon) begin
         leap   <= leap + 2'd1;
      end
   end

   assign roll_now[0] = step;
   assign roll_now[1] = step && (frac[3:0] == 4'h9);
   assign roll_now[2] = c_frac;
   assign roll_now[3] = c_frac && (sec[3:0] == 4'h9);
   assign roll_now[4] = c_sec;

   if (REG_ROLL) begin : g_roll_reg
      always_ff @(posedge clk) begin
         if (!rst_n) roll <= '0;
         else        roll <= roll_now;
      end
      assert_stop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !run |=> (roll == '0));
   end else begin : g_roll_comb
      assign roll = roll_now;
   end

   always_comb begin
      case (rd_addr)
         ADDR_W'(A_FRAC): rd_data = frac;
         ADDR_W'(A_SEC):  rd_data = sec;
         ADDR_W'(A_MIN):  rd_data = mins;
         ADDR_W'(A_HOUR): rd_data = hour;
         ADDR_W'(A_DOM):  rd_data = dom;
         ADDR_W'(A_MON):  rd_data = mon;
         ADDR_W'(A_YEAR): rd_data = year;
         ADDR_W'(A_DOYL): rd_data = doy[7:0];
         ADDR_W'(A_DOYH): rd_data = {4'h0, doy[11:8]};
         ADDR_W'(A_DOW):  rd_data = dow;
         ADDR_W'(A_CTRL): rd_data = {2'b00, leap, 2'b00, mode12, run};
         default:         rd_data = 8'h00;
      endcase
   end

   assert_stop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_en) |=> $stable(frac));
   assert_leap_adv_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (c_mon && !wsel[A_CTRL]) |=> (leap == $past(leap) + 2'd1));
   assert_roll_nest_R11: assert property (@(posedge clk) disable iff (!rst_n)
      roll[4] |-> (roll[3] && roll[2] && roll[1] && roll[0]));
   assert_year_wraps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (c_year && !wsel[A_YEAR]) |=> (year == 8'h00));
   assert_dow_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (c_dow && !wsel[A_DOW]) |=> (dow == 8'h01));

endmodule

// File: tb/cal_chain_test.sv
module cal_chain_test;
   import cal_pkg::*;

   typedef struct packed {
      logic [7:0] ctrl, frac, sec, min, hour, dom, mon, year, doyh, doyl, dow;
   } snap_t;

   typedef struct packed {
      logic [3:0] req;
      snap_t      pre;
      snap_t      post;
      logic [4:0] rl;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VEC [NV] = '{
      // R1: single hundredths step
      '{4'd1, '{8'h01,8'h00,8'h00,8'h00,8'h00,8'h01,8'h01,8'h00,8'h00,8'h01,8'h01},
              '{8'h01,8'h01,8'h00,8'h00,8'h00,8'h01,8'h01,8'h00,8'h00,8'h01,8'h01}, 5'b00001},
      // R1: digit carry inside hundredths byte
      '{4'd1, '{8'h01,8'h09,8'h00,8'h00,8'h00,8'h01,8'h01,8'h00,8'h00,8'h01,8'h01},
              '{8'h01,8'h10,8'h00,8'h00,8'h00,8'h01,8'h01,8'h00,8'h00,8'h01,8'h01}, 5'b00011},
      // R2: hundredths wrap into seconds
      '{4'd2, '{8'h01,8'h99,8'h00,8'h00,8'h00,8'h01,8'h01,8'h00,8'h00,8'h01,8'h01},
              '{8'h01,8'h00,8'h01,8'h00,8'h00,8'h01,8'h01,8'h00,8'h00,8'h01,8'h01}, 5'b00111},
      // R2: ten-second digit
      '{4'd2, '{8'h01,8'h99,8'h09,8'h00,8'h00,8'h01,8'h01,8'h00,8'h00,8'h01,8'h01},
              '{8'h01,8'h00,8'h10,8'h00,8'h00,8'h01,8'h01,8'h00,8'h00,8'h01,8'h01}, 5'b01111},
      // R2: minute advance
      '{4'd2, '{8'h01,8'h99,8'h59,8'h00,8'h00,8'h01,8'h01,8'h00,8'h00,8'h01,8'h01},
              '{8'h01,8'h00,8'h00,8'h01,8'h00,8'h01,8'h01,8'h00,8'h00,8'h01,8'h01}, 5'b11111},
      // R3: 24-hour digit carry 09 -> 10
      '{4'd3, '{8'h01,8'h99,8'h59,8'h59,8'h09,8'h01,8'h01,8'h00,8'h00,8'h01,8'h01},
              '{8'h01,8'h00,8'h00,8'h00,8'h10,8'h01,8'h01,8'h00,8'h00,8'h01,8'h01}, 5'b11111},
      // R3: 23 -> 00 with day carry
      '{4'd3, '{8'h01,8'h99,8'h59,8'h59,8'h23,8'h15,8'h06,8'h24,8'h01,8'h66,8'h03},
              '{8'h01,8'h00,8'h00,8'h00,8'h00,8'h16,8'h06,8'h24,8'h01,8'h67,8'h04}, 5'b11111},
      // R4: 11 AM -> 12 PM, no day carry
      '{4'd4, '{8'h03,8'h99,8'h59,8'h59,8'h11,8'h05,8'h03,8'h24,8'h00,8'h65,8'h02},
              '{8'h03,8'h00,8'h00,8'h00,8'h92,8'h05,8'h03,8'h24,8'h00,8'h65,8'h02}, 5'b11111},
      // R4: 12 PM -> 01 PM
      '{4'd4, '{8'h03,8'h99,8'h59,8'h59,8'h92,8'h05,8'h03,8'h24,8'h00,8'h65,8'h02},
              '{8'h03,8'h00,8'h00,8'h00,8'h81,8'h05,8'h03,8'h24,8'h00,8'h65,8'h02}, 5'b11111},
      // R4 R8: 11 PM -> 12 AM with day carry, weekday 7 -> 1
      '{4'd4, '{8'h03,8'h99,8'h59,8'h59,8'h91,8'h10,8'h03,8'h24,8'h00,8'h70,8'h07},
              '{8'h03,8'h00,8'h00,8'h00,8'h12,8'h11,8'h03,8'h24,8'h00,8'h71,8'h01}, 5'b11111},
      // R5: 30-day month end
      '{4'd5, '{8'h01,8'h99,8'h59,8'h59,8'h23,8'h30,8'h04,8'h24,8'h01,8'h21,8'h02},
              '{8'h01,8'h00,8'h00,8'h00,8'h00,8'h01,8'h05,8'h24,8'h01,8'h22,8'h03}, 5'b11111},
      // R5: 31-day month end
      '{4'd5, '{8'h01,8'h99,8'h59,8'h59,8'h23,8'h31,8'h01,8'h24,8'h00,8'h31,8'h05},
              '{8'h01,8'h00,8'h00,8'h00,8'h00,8'h01,8'h02,8'h24,8'h00,8'h32,8'h06}, 5'b11111},
      // R5: Feb 28 ends month when leap count is 1
      '{4'd5, '{8'h11,8'h99,8'h59,8'h59,8'h23,8'h28,8'h02,8'h25,8'h00,8'h59,8'h01},
              '{8'h11,8'h00,8'h00,8'h00,8'h00,8'h01,8'h03,8'h25,8'h00,8'h60,8'h02}, 5'b11111},
      // R5: Feb 28 -> 29 when leap count is 0
      '{4'd5, '{8'h01,8'h99,8'h59,8'h59,8'h23,8'h28,8'h02,8'h24,8'h00,8'h59,8'h01},
              '{8'h01,8'h00,8'h00,8'h00,8'h00,8'h29,8'h02,8'h24,8'h00,8'h60,8'h02}, 5'b11111},
      // R5: Feb 29 -> Mar 1
      '{4'd5, '{8'h01,8'h99,8'h59,8'h59,8'h23,8'h29,8'h02,8'h24,8'h00,8'h60,8'h02},
              '{8'h01,8'h00,8'h00,8'h00,8'h00,8'h01,8'h03,8'h24,8'h00,8'h61,8'h03}, 5'b11111},
      // R6: leap-year end, leap count 0 -> 1
      '{4'd6, '{8'h01,8'h99,8'h59,8'h59,8'h23,8'h31,8'h12,8'h24,8'h03,8'h66,8'h04},
              '{8'h11,8'h00,8'h00,8'h00,8'h00,8'h01,8'h01,8'h25,8'h00,8'h01,8'h05}, 5'b11111},
      // R6: year 99 -> 00, leap count 3 -> 0
      '{4'd6, '{8'h31,8'h99,8'h59,8'h59,8'h23,8'h31,8'h12,8'h99,8'h03,8'h65,8'h07},
              '{8'h01,8'h00,8'h00,8'h00,8'h00,8'h01,8'h01,8'h00,8'h00,8'h01,8'h01}, 5'b11111},
      // R7: day 365 -> 366 in a leap year
      '{4'd7, '{8'h01,8'h99,8'h59,8'h59,8'h23,8'h30,8'h12,8'h24,8'h03,8'h65,8'h03},
              '{8'h01,8'h00,8'h00,8'h00,8'h00,8'h31,8'h12,8'h24,8'h03,8'h66,8'h04}, 5'b11111},
      // R7: day 365 wraps to 001 in a non-leap year, independent of month
      '{4'd7, '{8'h11,8'h99,8'h59,8'h59,8'h23,8'h10,8'h06,8'h25,8'h03,8'h65,8'h03},
              '{8'h11,8'h00,8'h00,8'h00,8'h00,8'h11,8'h06,8'h25,8'h00,8'h01,8'h04}, 5'b11111},
      // R9: stopped chain ignores the tick
      '{4'd9, '{8'h00,8'h45,8'h59,8'h59,8'h23,8'h31,8'h12,8'h99,8'h03,8'h65,8'h07},
              '{8'h00,8'h45,8'h59,8'h59,8'h23,8'h31,8'h12,8'h99,8'h03,8'h65,8'h07}, 5'b00000}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [3:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       presc_en;
   logic [4:0] roll;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   cal_chain uut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .presc_en(presc_en), .roll(roll));

   task automatic drive(input logic t, input logic w, input int a, input logic [7:0] d);
      @(negedge clk);
      tick = t; wr_en = w; wr_addr = a[3:0]; wr_data = d;
      @(negedge clk);
      tick = 1'b0; wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output logic [7:0] v);
      rd_addr = a[3:0];
      #1;
      v = rd_data;
   endtask

   task automatic snap(output snap_t s);
      rd(A_CTRL, s.ctrl); rd(A_FRAC, s.frac); rd(A_SEC, s.sec); rd(A_MIN, s.min);
      rd(A_HOUR, s.hour); rd(A_DOM, s.dom); rd(A_MON, s.mon); rd(A_YEAR, s.year);
      rd(A_DOYH, s.doyh); rd(A_DOYL, s.doyl); rd(A_DOW, s.dow);
   endtask

   task automatic load(input snap_t s);
      drive(0, 1, A_CTRL, s.ctrl); drive(0, 1, A_FRAC, s.frac); drive(0, 1, A_SEC, s.sec);
      drive(0, 1, A_MIN, s.min);   drive(0, 1, A_HOUR, s.hour); drive(0, 1, A_DOM, s.dom);
      drive(0, 1, A_MON, s.mon);   drive(0, 1, A_YEAR, s.year); drive(0, 1, A_DOYH, s.doyh);
      drive(0, 1, A_DOYL, s.doyl); drive(0, 1, A_DOW, s.dow);
   endtask

   task automatic check8(input string req, input logic [7:0] got, input logic [7:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   initial begin
      snap_t s;
      logic [4:0] r;
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12: reset state
      snap(s);
      total++;
      if (s !== snap_t'({8'h00,8'h00,8'h00,8'h00,8'h00,8'h01,8'h01,8'h00,8'h00,8'h01,8'h01})
          || presc_en !== 1'b0 || roll !== 5'b0) begin
         bad++;
         $display("FAIL R12: got %h pe=%b roll=%b expected reset image", s, presc_en, roll);
      end

      // R9: prescaler enable follows run bit
      drive(0, 1, A_CTRL, 8'h01);
      check8("R9 presc_en", {7'b0, presc_en}, 8'h01);

      for (int i = 0; i < NV; i++) begin
         load(VEC[i].pre);
         drive(1, 0, 0, 8'h00);
         r = roll;
         snap(s);
         total++;
         if (s !== VEC[i].post || r !== VEC[i].rl) begin
            bad++;
            $display("FAIL R%0d vector %0d: got %h roll=%b expected %h roll=%b",
                     VEC[i].req, i, s, r, VEC[i].post, VEC[i].rl);
         end
      end

      // R9: stopped chain drives presc_en low
      check8("R9 presc_en stopped", {7'b0, presc_en}, 8'h00);

      // R10: write to seconds beats its own increment
      load('{8'h01,8'h99,8'h05,8'h00,8'h00,8'h01,8'h01,8'h00,8'h00,8'h01,8'h01});
      drive(1, 1, A_SEC, 8'h30);
      rd(A_SEC, v);  check8("R10 sec written", v, 8'h30);
      rd(A_FRAC, v); check8("R10 frac wrapped", v, 8'h00);

      // R10: write to hundredths while its pre-write value still carries
      drive(0, 1, A_FRAC, 8'h99);
      drive(1, 1, A_FRAC, 8'h42);
      rd(A_FRAC, v); check8("R10 frac written", v, 8'h42);
      rd(A_SEC, v);  check8("R10 carry from old frac", v, 8'h31);

      // R11: pulse lasts one cycle only
      drive(1, 0, 0, 8'h00);
      @(negedge clk);
      check8("R11 pulse cleared", {3'b0, roll}, 8'h00);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule